// File: doc/BRIEF.md
# Time-Multiplexed Neighbour Reorder Port

In a time-multiplexed network model a single router model is stepped through every logical node in index order, one node per slot. If the port that carries a message out of one node were looped straight back into the same model, every node would only ever hear from itself. This block is the inbound side of such a loopback. It captures the message produced in each instance slot of a model cycle. It then hands each instance, in its own slot, the message that its neighbour sent. The outbound side holds no storage; all buffering for the permutation lives here.

The node grid is `width × height` instances, loaded once at start-up. A compile-time mode picks the neighbour relation. The two row modes rotate by one place inside each row of `width` instances, one pulling from the left column and one from the right. The two ring modes rotate the whole sequence by one full row, one pulling from a row ahead and one from a row behind. Every slot carries a valid bit, and empty slots travel through the port like full ones, so slot positions never drift. Two complete model cycles can be held, so the writer can fill the next cycle while the reader drains the current one.

Top module: `tmx_reorder_port`

## Requirements
- R1: After reset `rdReady` is low, the grid is 1 × 1, the configuration is unlocked and both buffers are empty.
- R2: A configuration load is taken only when the port is unlocked, both dimensions are non-zero and their product is at most `TMX_MAX_NODES` (16). The first load that is taken locks the configuration until reset; every later load is ignored.
- R3: Writes are numbered 0 to N−1 (N = width × height) in the order they are accepted. The cycle becomes readable only after the N-th write, and `rdReady` rises on that write's clock edge.
- R4: Mode `ROW_PULL_LEFT` (encoding 0): the instance at column c of a row receives the message sent by column (c−1) mod width of the same row.
- R5: Mode `ROW_PULL_RIGHT` (encoding 1): the instance at column c receives from column (c+1) mod width of the same row.
- R6: Mode `RING_AHEAD_ROW` (encoding 2): instance x receives from instance (x + width) mod N.
- R7: Mode `RING_BEHIND_ROW` (encoding 3): instance x receives from instance (x − width) mod N.
- R8: A slot written with `wrMsgValid` low is delivered with `rdMsgValid` low at the slot its receiver maps to. It still takes up one position in the cycle.
- R9: Two complete cycles are buffered and are read in the order they were written. A write made while both buffers hold complete cycles is ignored and does not advance the slot count.
- R10: While `rdReady` is low, `rdEn` is ignored. An accepted read steps to the next instance. After the N-th read the buffer is released, and `rdReady` stays low unless the other buffer is already complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgLoad | input | 1 | Load strobe for the grid dimensions |
| cfgWidth | input | DIM_W (5) | Instances per row |
| cfgHeight | input | DIM_W (5) | Number of rows |
| wrEn | input | 1 | Write the message for the next instance slot |
| wrMsgValid | input | 1 | Valid bit of the written slot |
| wrData | input | DATA_W | Payload of the written slot |
| rdEn | input | 1 | Consume the current receive slot |
| rdReady | output | 1 | A complete model cycle is available |
| rdMsgValid | output | 1 | Valid bit delivered to the current receiving instance |
| rdData | output | DATA_W | Payload delivered to the current receiving instance |

## Verification
A configuration load and every write act on the rising edge at which they are presented. `rdReady` therefore rises one edge after the final write of a cycle is driven. The receive slot (`rdMsgValid`, `rdData`) is a combinational view of buffered state. It is valid in the same cycle as `rdReady` and moves on one instance at each edge that accepts a read. The bench drives each operation on a falling edge, removes it on the next falling edge, and samples the outputs only there, a half period after the edge that settled them. Four instances, one per mode, share the same stimulus, so each permutation is compared against an index formula computed in the bench.

// File: rtl/tmx_pkg.sv
package tmx_pkg;

  // Largest grid the port can hold; all index widths follow from it.
  parameter int unsigned TMX_MAX_NODES = 16;
  localparam int unsigned IDX_W = $clog2(TMX_MAX_NODES);
  localparam int unsigned DIM_W = $clog2(TMX_MAX_NODES + 1);
  localparam int unsigned SUM_W = DIM_W + 1;

  typedef enum logic [1:0] {
    ROW_PULL_LEFT   = 2'd0,
    ROW_PULL_RIGHT  = 2'd1,
    RING_AHEAD_ROW  = 2'd2,
    RING_BEHIND_ROW = 2'd3
  } reorder_mode_e;

  // Control-to-datapath strobes and indices.
  typedef struct packed {
    logic             wrStore;
    logic             wrBank;
    logic [IDX_W-1:0] wrIdx;
    logic             rdBank;
    logic [IDX_W-1:0] rdIdx;
    logic [IDX_W-1:0] rdCol;
    logic [DIM_W-1:0] width;
    logic [DIM_W-1:0] count;
  } strobe_t;

endpackage

// File: rtl/tmx_reorder_ctrl.sv
module tmx_reorder_ctrl
  import tmx_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgLoad,
  input  logic [DIM_W-1:0] cfgWidth,
  input  logic [DIM_W-1:0] cfgHeight,
  input  logic             wrEn,
  input  logic             rdEn,
  output strobe_t          strobe,
  output logic             rdReady,
  output logic [1:0]       bankFull,
  output logic             cfgLocked
);

  localparam int unsigned PROD_W = 2 * DIM_W;

  logic [DIM_W-1:0]  widthQ, countQ;
  logic              lockedQ;
  logic              wrBankQ, rdBankQ;
  logic [IDX_W-1:0]  wrIdxQ, rdIdxQ, rdColQ;
  logic [1:0]        fullQ;

  logic [PROD_W-1:0] cfgProd;
  logic              cfgTake;
  logic [DIM_W-1:0]  lastIdx, lastCol;
  logic              wrAccept, wrLast, rdAccept, rdLast, rdColLast;

  always_comb begin
    cfgProd  = {{DIM_W{1'b0}}, cfgWidth} * {{DIM_W{1'b0}}, cfgHeight};
    cfgTake  = cfgLoad && !lockedQ && (cfgWidth != '0) && (cfgHeight != '0)
               && (cfgProd <= PROD_W'(TMX_MAX_NODES));
    lastIdx  = countQ - DIM_W'(1);
    lastCol  = widthQ - DIM_W'(1);
    wrAccept = wrEn && !fullQ[wrBankQ];
    wrLast   = ({1'b0, wrIdxQ} == lastIdx);
    rdAccept = rdEn && fullQ[rdBankQ];
    rdLast   = ({1'b0, rdIdxQ} == lastIdx);
    rdColLast = ({1'b0, rdColQ} == lastCol);
  end

  // Configuration registers: first legal load wins until reset.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      widthQ  <= DIM_W'(1);
      countQ  <= DIM_W'(1);
      lockedQ <= 1'b0;
    end else if (cfgTake) begin
      widthQ  <= cfgWidth;
      countQ  <= cfgProd[DIM_W-1:0];
      lockedQ <= 1'b1;
    end
  end

  // Write sequencing.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrIdxQ  <= '0;
      wrBankQ <= 1'b0;
    end else if (wrAccept) begin
      if (wrLast) begin
        wrIdxQ  <= '0;
        wrBankQ <= !wrBankQ;
      end else begin
        wrIdxQ <= wrIdxQ + IDX_W'(1);
      end
    end
  end

  // Read sequencing with a column tracker for the row modes.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdIdxQ  <= '0;
      rdColQ  <= '0;
      rdBankQ <= 1'b0;
    end else if (rdAccept) begin
      if (rdLast) begin
        rdIdxQ  <= '0;
        rdColQ  <= '0;
        rdBankQ <= !rdBankQ;
      end else begin
        rdIdxQ <= rdIdxQ + IDX_W'(1);
        rdColQ <= rdColLast ? '0 : rdColQ + IDX_W'(1);
      end
    end
  end

  // Per-bank completion flags.
  for (genvar b = 0; b < 2; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rstN) begin
        fullQ[b] <= 1'b0;
      end else if (wrAccept && wrLast && (wrBankQ == 1'(b))) begin
        fullQ[b] <= 1'b1;
      end else if (rdAccept && rdLast && (rdBankQ == 1'(b))) begin
        fullQ[b] <= 1'b0;
      end
    end
  end

  always_comb begin
    strobe.wrStore = wrAccept;
    strobe.wrBank  = wrBankQ;
    strobe.wrIdx   = wrIdxQ;
    strobe.rdBank  = rdBankQ;
    strobe.rdIdx   = rdIdxQ;
    strobe.rdCol   = rdColQ;
    strobe.width   = widthQ;
    strobe.count   = countQ;
    rdReady        = fullQ[rdBankQ];
    bankFull       = fullQ;
    cfgLocked      = lockedQ;
  end

endmodule

// File: rtl/tmx_reorder_dp.sv
module tmx_reorder_dp
  import tmx_pkg::*;
#(
  parameter reorder_mode_e MODE   = ROW_PULL_LEFT,
  parameter int unsigned   DATA_W = 32
) (
  input  logic              clk,
  input  strobe_t           strobe,
  input  logic              wrMsgValid,
  input  logic [DATA_W-1:0] wrData,
  output logic [SUM_W-1:0]  srcIdx,
  output logic              rdMsgValid,
  output logic [DATA_W-1:0] rdData
);

  localparam int unsigned SLOT_W = DATA_W + 1;

  logic [SLOT_W-1:0] slotMem [2][TMX_MAX_NODES];
  logic [SUM_W-1:0]  x, c, w, n;

  always_ff @(posedge clk) begin
    if (strobe.wrStore) begin
      slotMem[strobe.wrBank][strobe.wrIdx] <= {wrMsgValid, wrData};
    end
  end

  always_comb begin
    x = SUM_W'(strobe.rdIdx);
    c = SUM_W'(strobe.rdCol);
    w = SUM_W'(strobe.width);
    n = SUM_W'(strobe.count);
  end

  // Source instance for the current receiver, one variant per mode.
  if (MODE == ROW_PULL_LEFT) begin : g_left
    assign srcIdx = (c == '0) ? x + w - SUM_W'(1) : x - SUM_W'(1);
  end else if (MODE == ROW_PULL_RIGHT) begin : g_right
    assign srcIdx = (c == w - SUM_W'(1)) ? x - (w - SUM_W'(1)) : x + SUM_W'(1);
  end else if (MODE == RING_AHEAD_ROW) begin : g_ahead
    assign srcIdx = (x + w >= n) ? x + w - n : x + w;
  end else begin : g_behind
    assign srcIdx = (x < w) ? x + n - w : x - w;
  end

  logic [SLOT_W-1:0] rdSlot;
  always_comb begin
    rdSlot     = slotMem[strobe.rdBank][srcIdx[IDX_W-1:0]];
    rdMsgValid = rdSlot[DATA_W];
    rdData     = rdSlot[DATA_W-1:0];
  end

endmodule

// File: rtl/tmx_reorder_port.sv
module tmx_reorder_port
  import tmx_pkg::*;
#(
  parameter reorder_mode_e MODE   = ROW_PULL_LEFT,
  parameter int unsigned   DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgLoad,
  input  logic [DIM_W-1:0]  cfgWidth,
  input  logic [DIM_W-1:0]  cfgHeight,
  input  logic              wrEn,
  input  logic              wrMsgValid,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  output logic              rdReady,
  output logic              rdMsgValid,
  output logic [DATA_W-1:0] rdData
);

  strobe_t          strobe;
  logic [1:0]       bankFull;
  logic             cfgLocked;
  logic [SUM_W-1:0] srcIdx;

  tmx_reorder_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cfgLoad   (cfgLoad),
    .cfgWidth  (cfgWidth),
    .cfgHeight (cfgHeight),
    .wrEn      (wrEn),
    .rdEn      (rdEn),
    .strobe    (strobe),
    .rdReady   (rdReady),
    .bankFull  (bankFull),
    .cfgLocked (cfgLocked)
  );

  tmx_reorder_dp #(
    .MODE   (MODE),
    .DATA_W (DATA_W)
  ) u_dp (
    .clk        (clk),
    .strobe     (strobe),
    .wrMsgValid (wrMsgValid),
    .wrData     (wrData),
    .srcIdx     (srcIdx),
    .rdMsgValid (rdMsgValid),
    .rdData     (rdData)
  );

endmodule

// File: rtl/tmx_reorder_checker.sv
module tmx_reorder_checker
  import tmx_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic             rdReady,
  input strobe_t          strobe,
  input logic [1:0]       bankFull,
  input logic             cfgLocked,
  input logic [SUM_W-1:0] srcIdx
);

  assert_ready_clear_after_reset_R1: assert property (
    @(posedge clk) disable iff (!rstN) $rose(rstN) |-> !rdReady);

  assert_cfg_frozen_R2: assert property (
    @(posedge clk) disable iff (!rstN)
      cfgLocked |=> cfgLocked && $stable(strobe.width) && $stable(strobe.count));

  assert_wr_slot_in_range_R3: assert property (
    @(posedge clk) disable iff (!rstN) {1'b0, strobe.wrIdx} < strobe.count);

  // Source index bounded for every mode: R4 R5 R6 R7
  assert_src_in_range_R4: assert property (
    @(posedge clk) disable iff (!rstN) srcIdx < SUM_W'(strobe.count));

  assert_full_write_ignored_R9: assert property (
    @(posedge clk) disable iff (!rstN)
      (&bankFull) && wrEn |=> $stable(strobe.wrIdx) && $stable(strobe.wrBank));

  assert_idle_stays_unready_R10: assert property (
    @(posedge clk) disable iff (!rstN) !rdReady && !wrEn |=> !rdReady);

  assert_rd_slot_in_range_R10: assert property (
    @(posedge clk) disable iff (!rstN) {1'b0, strobe.rdIdx} < strobe.count);

endmodule

bind tmx_reorder_port tmx_reorder_checker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .wrEn      (wrEn),
  .rdReady   (rdReady),
  .strobe    (strobe),
  .bankFull  (bankFull),
  .cfgLocked (cfgLocked),
  .srcIdx    (srcIdx)
);

// File: tb/tb_tmx_reorder_port.sv
module tb_tmx_reorder_port;
  import tmx_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W     = 8;
  localparam int NMODE      = 4;

  typedef struct packed {
    logic [7:0]  seed;
    logic [15:0] mask;
  } vec_t;

  // Per-cycle stimulus; expected receive slots are derived from it.
  localparam vec_t TABLE [5] = '{
    '{seed: 8'h10, mask: 16'hFFFF},
    '{seed: 8'h4A, mask: 16'h0015},
    '{seed: 8'h83, mask: 16'h002A},
    '{seed: 8'hC7, mask: 16'h0000},
    '{seed: 8'h25, mask: 16'h0021}
  };

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic              rstN = 1'b0, cfgLoad = 1'b0, wrEn = 1'b0, wrMsgValid = 1'b0, rdEn = 1'b0;
  logic [DIM_W-1:0]  cfgWidth = '0, cfgHeight = '0;
  logic [DATA_W-1:0] wrData = '0;
  logic              rdReadyV [NMODE];
  logic              rdValidV [NMODE];
  logic [DATA_W-1:0] rdDataV  [NMODE];

  for (genvar m = 0; m < NMODE; m++) begin : g_mode
    tmx_reorder_port #(.MODE(reorder_mode_e'(m)), .DATA_W(DATA_W)) dut (
      .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad), .cfgWidth(cfgWidth), .cfgHeight(cfgHeight),
      .wrEn(wrEn), .wrMsgValid(wrMsgValid), .wrData(wrData), .rdEn(rdEn),
      .rdReady(rdReadyV[m]), .rdMsgValid(rdValidV[m]), .rdData(rdDataV[m]));
  end

  int checks = 0, fails = 0;
  int benchW = 1, benchH = 1;
  bit finished = 0;
  logic              sentValid [2][16];
  logic [DATA_W-1:0] sentData  [2][16];
  string modeReq [NMODE] = '{"R4", "R5", "R6", "R7"};

  function automatic int srcOf(int mode, int x, int w, int n);
    int col = x % w;
    int base = x - col;
    case (mode)
      0:       return base + (col + w - 1) % w;
      1:       return base + (col + 1) % w;
      2:       return (x + w) % n;
      default: return (x + n - w) % n;
    endcase
  endfunction

  task automatic checkEq(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic checkReadyAll(string req, string what, int exp);
    for (int m = 0; m < NMODE; m++) checkEq(req, what, int'(rdReadyV[m]), exp);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    benchW = 1;
    benchH = 1;
    @(negedge clk);
  endtask

  task automatic loadCfg(int w, int h);
    @(negedge clk);
    cfgWidth = DIM_W'(w);
    cfgHeight = DIM_W'(h);
    cfgLoad = 1'b1;
    @(negedge clk);
    cfgLoad = 1'b0;
  endtask

  task automatic writeSlot(logic v, logic [DATA_W-1:0] d);
    @(negedge clk);
    wrEn = 1'b1;
    wrMsgValid = v;
    wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic pulseRead();
    @(negedge clk);
    rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  // Write one model cycle into bench slot buffer b.
  task automatic writeCycle(int b, vec_t v, bit checkLate);
    int n = benchW * benchH;
    for (int i = 0; i < n; i++) begin
      sentValid[b][i] = v.mask[i];
      sentData[b][i]  = DATA_W'(int'(v.seed) + i * 5);
      if (checkLate && i == n - 1) checkReadyAll("R3", "ready before last write", 0);
      writeSlot(sentValid[b][i], sentData[b][i]);
    end
    if (checkLate) checkReadyAll("R3", "ready after last write", 1);
  endtask

  task automatic readCycle(int b);
    int n = benchW * benchH;
    for (int x = 0; x < n; x++) begin
      for (int m = 0; m < NMODE; m++) begin
        int s = srcOf(m, x, benchW, n);
        checkEq("R10", "ready during drain", int'(rdReadyV[m]), 1);
        checkEq("R8", "slot valid bit", int'(rdValidV[m]), int'(sentValid[b][s]));
        checkEq(modeReq[m], "slot payload", int'(rdDataV[m]), int'(sentData[b][s]));
      end
      pulseRead();
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected done");
      summary();
    end
  end

  initial begin
    // R1: reset state
    doReset();
    checkReadyAll("R1", "ready after reset", 0);

    // R2: oversized load ignored, legal load taken, later load ignored
    loadCfg(5, 4);
    loadCfg(3, 2);
    loadCfg(2, 3);
    benchW = 3;
    benchH = 2;

    // R10: read while unready has no effect
    pulseRead();
    checkReadyAll("R10", "ready after stray read", 0);

    // Table walk: each entry one full model cycle
    for (int e = 0; e < 5; e++) begin
      writeCycle(0, TABLE[e], 1'b1);
      readCycle(0);
      checkReadyAll("R10", "ready after drain", 0);
    end

    // R9: two cycles buffered, extra writes ignored when both full
    writeCycle(0, TABLE[1], 1'b0);
    writeCycle(1, TABLE[2], 1'b0);
    checkReadyAll("R9", "ready with two cycles", 1);
    writeSlot(1'b1, 8'hEE);
    writeSlot(1'b1, 8'hDD);
    readCycle(0);
    checkReadyAll("R9", "second cycle ready", 1);
    readCycle(1);
    checkReadyAll("R9", "ready after both drained", 0);
    writeCycle(0, TABLE[4], 1'b1);
    readCycle(0);

    // Largest grid: 4 x 4 fills the buffer
    doReset();
    checkReadyAll("R1", "ready after second reset", 0);
    loadCfg(4, 4);
    benchW = 4;
    benchH = 4;
    writeCycle(0, TABLE[0], 1'b1);
    readCycle(0);
    writeCycle(0, TABLE[4], 1'b1);
    readCycle(0);

    // Single column: row modes map to self, ring modes shift by one
    doReset();
    loadCfg(1, 4);
    benchW = 1;
    benchH = 4;
    writeCycle(0, TABLE[2], 1'b1);
    readCycle(0);

    // R2: zero dimension rejected, default 1 x 1 stays in force
    doReset();
    loadCfg(0, 3);
    writeCycle(0, TABLE[0], 1'b1);
    readCycle(0);
    checkReadyAll("R2", "ready after single-slot drain", 0);

    finished = 1;
    summary();
  end

endmodule